// File: doc/BRIEF.md
# Indirect Table Window

This block lets software reach a set of internal tables through two bus registers: a pointer register and a data register. The pointer register names one of fourteen tables, an entry index and an auto-advance flag. A read or write of the data register is forwarded to the named table. The index is first clipped to that table's depth. Each table has its own depth, between 4 and 512 entries. When auto-advance is on, the pointer steps to the next entry after the access and wraps within the table. Software can therefore stream through a whole table with repeated data accesses.

Six of the tables have storage behind them, reached through a one-hot enable, a shared index and write-data bus, and one read-data slice per table. The other eight are accepted and advance the pointer, but nothing is stored: writes are dropped and reads return zero. Select codes outside the fourteen defined ones perform no access at all. A one-cycle flag reports any access whose raw index had bits above the table's depth.

Top module: `tbl_window`

## Requirements
- R1: After reset the pointer register reads as zero, `bus_rvalid` and `idx_clip` are low and no table enable is active.
- R2: The pointer register keeps the index in bits 8:0, the table select in bits 19:16 and the auto-advance flag in bit 31. All other bits read as zero, and writes to them are discarded.
- R3: A data access (`bus_reg`=1) to a backed table raises only that table's bit of `tbl_en` for that cycle. It drives `tbl_idx` with the clipped index, `tbl_we` with the access direction and `tbl_wdata` with the bus data.
- R4: Table selects and index masks are: 0→7, 1→7, 2→31, 3→31, 4→63, 5→7, 6→255, 7→255, 8→511, 9→63, 10→63, 11→15, 12→255, 13→3. The index used is the stored index ANDed with the mask.
- R5: Every bus read returns its data on `bus_rdata`, with `bus_rvalid` high, in the cycle after the request. A pointer read returns the register image. A data read of a backed table returns that table's `tbl_rdata` slice, in which table t occupies bits t*64+63:t*64.
- R6: With auto-advance set, a data access to a known table stores ((clipped index + 1) AND mask) into the pointer's index field, so the last entry wraps to 0.
- R7: Tables 2–7, 9 and 10 have no storage. Data accesses to them raise no enable, reads of them return zero, and auto-advance still applies.
- R8: Select codes 14 and 15 are unknown. Data accesses to them raise no enable, return zero on read, and leave the pointer unchanged even with auto-advance set.
- R9: `idx_clip` is high for one cycle after a data access to a known table whose stored index has a bit set outside that table's mask, and low otherwise.
- R10: With auto-advance clear, data accesses leave the pointer register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus request strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_reg | input | 1 | 0 = pointer register, 1 = data register |
| bus_wdata | input | 64 | Bus write data |
| bus_rdata | output | 64 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe |
| tbl_en | output | 14 | One-hot table enable |
| tbl_we | output | 1 | Table write enable |
| tbl_idx | output | 9 | Clipped table index |
| tbl_wdata | output | 64 | Table write data |
| tbl_rdata | input | 896 | Read data from each table, 64 bits per table |
| idx_clip | output | 1 | Out-of-range index flag |

## Verification
The table enable, index and write data are combinational, so the bench samples them in the same cycle as the request, before the clock edge. Read data, `bus_rvalid`, `idx_clip` and the pointer update are all registered at the request's edge. The bench checks each of these one step after that edge. It confirms a pointer update by reading the pointer back in the next request. This also shows that ignored writes and non-advancing accesses left the state untouched.

// File: rtl/tbl_window.sv
module tbl_window #(
  parameter int DW    = 64,
  parameter int IDX_W = 9,
  parameter int SEL_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_req,
  input  logic                 bus_wr,
  input  logic                 bus_reg,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic                 bus_rvalid,
  output logic [13:0]          tbl_en,
  output logic                 tbl_we,
  output logic [IDX_W-1:0]     tbl_idx,
  output logic [DW-1:0]        tbl_wdata,
  input  logic [14*DW-1:0]     tbl_rdata,
  output logic                 idx_clip
);
  localparam int NTBL    = 14;
  localparam int SEL_LSB = 16;
  localparam int INC_BIT = 31;

  function automatic logic [IDX_W-1:0] mask_of(input logic [SEL_W-1:0] s);
    case (s)
      4'd0, 4'd1, 4'd5:         mask_of = IDX_W'(7);
      4'd2, 4'd3:               mask_of = IDX_W'(31);
      4'd4, 4'd9, 4'd10:        mask_of = IDX_W'(63);
      4'd6, 4'd7, 4'd12:        mask_of = IDX_W'(255);
      4'd8:                     mask_of = IDX_W'(511);
      4'd11:                    mask_of = IDX_W'(15);
      4'd13:                    mask_of = IDX_W'(3);
      default:                  mask_of = '0;
    endcase
  endfunction

  function automatic logic backed_of(input logic [SEL_W-1:0] s);
    case (s)
      4'd0, 4'd1, 4'd8, 4'd11, 4'd12, 4'd13: backed_of = 1'b1;
      default:                               backed_of = 1'b0;
    endcase
  endfunction

  logic [IDX_W-1:0] idx_q;
  logic [SEL_W-1:0] sel_q;
  logic             inc_q;
  logic             clip_q;

  logic             known, backed, hit, ptr_wr;
  logic [IDX_W-1:0] mask, idx_eff, idx_next;
  logic [DW-1:0]    ptr_img, sel_data;

  assign known    = (sel_q < SEL_W'(NTBL));
  assign backed   = backed_of(sel_q);
  assign mask     = mask_of(sel_q);
  assign hit      = bus_req && bus_reg;
  assign ptr_wr   = bus_req && !bus_reg && bus_wr;
  assign idx_eff  = idx_q & mask;
  assign idx_next = (idx_eff + 1'b1) & mask;

  assign tbl_we    = bus_wr;
  assign tbl_idx   = idx_eff;
  assign tbl_wdata = bus_wdata;
  assign idx_clip  = clip_q;

  for (genvar t = 0; t < NTBL; t++) begin : g_en
    assign tbl_en[t] = hit && backed && (sel_q == SEL_W'(t));
  end

  always_comb begin
    sel_data = '0;
    for (int t = 0; t < NTBL; t++)
      if (sel_q == SEL_W'(t)) sel_data = tbl_rdata[t*DW +: DW];
    if (!backed) sel_data = '0;
  end

  always_comb begin
    ptr_img = '0;
    ptr_img[IDX_W-1:0]          = idx_q;
    ptr_img[SEL_LSB +: SEL_W]   = sel_q;
    ptr_img[INC_BIT]            = inc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q      <= '0;
      sel_q      <= '0;
      inc_q      <= 1'b0;
      clip_q     <= 1'b0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_req && !bus_wr;
      clip_q     <= hit && known && ((idx_q & ~mask) != '0);
      if (bus_req && !bus_wr)
        bus_rdata <= bus_reg ? sel_data : ptr_img;
      if (ptr_wr) begin
        idx_q <= bus_wdata[IDX_W-1:0];
        sel_q <= bus_wdata[SEL_LSB +: SEL_W];
        inc_q <= bus_wdata[INC_BIT];
      end else if (hit && known && inc_q) begin
        idx_q <= idx_next;
      end
    end
  end
endmodule

// File: rtl/tbl_window_chk.sv
module tbl_window_chk #(
  parameter int IDX_W = 9,
  parameter int SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_req,
  input logic             bus_wr,
  input logic             bus_reg,
  input logic [13:0]      tbl_en,
  input logic [IDX_W-1:0] tbl_idx,
  input logic             bus_rvalid,
  input logic             idx_clip,
  input logic [IDX_W-1:0] idx_q,
  input logic [SEL_W-1:0] sel_q,
  input logic             inc_q
);
  AST_ONE_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tbl_en)); // R3
  AST_EVEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_en[13] |-> tbl_idx < IDX_W'(4)); // R4
  AST_BAR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_en[11] |-> tbl_idx < IDX_W'(16)); // R4
  AST_READ_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr) |=> bus_rvalid); // R5
  AST_UNKNOWN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_reg && sel_q >= SEL_W'(14)) |-> tbl_en == '0); // R8
  AST_UNKNOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_reg && sel_q >= SEL_W'(14)) |=> $stable(idx_q)); // R8
  AST_UNKNOWN_NOCLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_reg && sel_q >= SEL_W'(14)) |=> !idx_clip); // R9
  AST_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_reg && !inc_q) |=> $stable(idx_q)); // R10
endmodule

bind tbl_window tbl_window_chk #(.IDX_W(IDX_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
  .bus_reg(bus_reg), .tbl_en(tbl_en), .tbl_idx(tbl_idx),
  .bus_rvalid(bus_rvalid), .idx_clip(idx_clip),
  .idx_q(idx_q), .sel_q(sel_q), .inc_q(inc_q)
);

// File: tb/tbl_window_tb.sv
module tbl_window_tb;
  logic          clk = 0, rst_n = 0;
  logic          bus_req = 0, bus_wr = 0, bus_reg = 0;
  logic [63:0]   bus_wdata = '0, bus_rdata;
  logic          bus_rvalid, tbl_we, idx_clip;
  logic [13:0]   tbl_en;
  logic [8:0]    tbl_idx;
  logic [63:0]   tbl_wdata;
  logic [895:0]  tbl_rdata;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  tbl_window u_dut (.*);

  always_comb
    for (int t = 0; t < 14; t++)
      tbl_rdata[t*64 +: 64] = {32'h0, 32'hC000_0000 | (32'(t) << 16) | 32'(tbl_idx)};

  typedef struct packed {
    logic [1:0]  op;   // 0 ptr write, 1 ptr read, 2 data read, 3 data write
    logic        clip;
    logic [31:0] arg;
    logic [31:0] exp;  // data write: {sel,idx} of stored write or FFFFFFFF for none
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{2'd0,1'b0,32'h0008_0005,32'h0},
    '{2'd2,1'b0,32'h0,32'hC008_0005},
    '{2'd1,1'b0,32'h0,32'h0008_0005},
    '{2'd0,1'b0,32'h800D_0006,32'h0},
    '{2'd2,1'b1,32'h0,32'hC00D_0002},
    '{2'd1,1'b0,32'h0,32'h800D_0003},
    '{2'd2,1'b0,32'h0,32'hC00D_0003},
    '{2'd1,1'b0,32'h0,32'h800D_0000},
    '{2'd0,1'b0,32'h800B_000F,32'h0},
    '{2'd3,1'b0,32'h0000_1234,32'h000B_000F},
    '{2'd1,1'b0,32'h0,32'h800B_0000},
    '{2'd0,1'b0,32'h8002_001F,32'h0},
    '{2'd2,1'b0,32'h0,32'h0},
    '{2'd1,1'b0,32'h0,32'h8002_0000},
    '{2'd3,1'b0,32'h0000_5678,32'hFFFF_FFFF},
    '{2'd1,1'b0,32'h0,32'h8002_0001},
    '{2'd0,1'b0,32'h800E_0033,32'h0},
    '{2'd2,1'b0,32'h0,32'h0},
    '{2'd3,1'b0,32'h0000_9ABC,32'hFFFF_FFFF},
    '{2'd1,1'b0,32'h0,32'h800E_0033},
    '{2'd0,1'b0,32'hFFFF_FFFF,32'h0},
    '{2'd1,1'b0,32'h0,32'h800F_01FF},
    '{2'd0,1'b0,32'h8008_01FF,32'h0},
    '{2'd2,1'b0,32'h0,32'hC008_01FF},
    '{2'd1,1'b0,32'h0,32'h8008_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int mask_of(input int s);
    case (s)
      0, 1, 5:   return 7;
      2, 3:      return 31;
      4, 9, 10:  return 63;
      6, 7, 12:  return 255;
      8:         return 511;
      11:        return 15;
      13:        return 3;
      default:   return 0;
    endcase
  endfunction

  logic [31:0] wr_tag;
  logic [63:0] wr_data;

  task automatic do_op(input logic [1:0] op, input logic [63:0] arg);
    @(negedge clk);
    bus_req = 1; bus_reg = op[1]; bus_wr = (op == 2'd0) || (op == 2'd3);
    bus_wdata = arg;
    #1;
    wr_tag = 32'hFFFF_FFFF; wr_data = '0;
    if (tbl_en != '0 && tbl_we) begin
      for (int t = 0; t < 14; t++)
        if (tbl_en[t]) wr_tag = (32'(t) << 16) | 32'(tbl_idx);
      wr_data = tbl_wdata;
    end
    @(posedge clk); #1;
    bus_req = 0; bus_wr = 0; bus_reg = 0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rvalid", 64'(bus_rvalid), 64'd0);
    chk("R1 clip", 64'(idx_clip), 64'd0);
    chk("R1 enable", 64'(tbl_en), 64'd0);
    rst_n = 1;
    do_op(2'd1, '0);
    chk("R1 pointer", bus_rdata, 64'd0);

    for (int v = 0; v < NV; v++) begin
      do_op(VEC[v].op, 64'(VEC[v].arg));
      case (VEC[v].op)
        2'd1: begin
          chk("R2 R6 R10 pointer", bus_rdata, 64'(VEC[v].exp));
          chk("R5 rvalid", 64'(bus_rvalid), 64'd1);
        end
        2'd2: begin
          chk("R5 R7 R8 read data", bus_rdata, 64'(VEC[v].exp));
          chk("R5 rvalid", 64'(bus_rvalid), 64'd1);
          chk("R9 clip", 64'(idx_clip), 64'(VEC[v].clip));
        end
        2'd3: begin
          chk("R3 R7 R8 write target", 64'(wr_tag), 64'(VEC[v].exp));
          if (VEC[v].exp != 32'hFFFF_FFFF) chk("R3 write data", wr_data, 64'(VEC[v].arg));
          chk("R9 clip", 64'(idx_clip), 64'(VEC[v].clip));
        end
        default: ;
      endcase
    end

    for (int t = 0; t < 14; t++) begin
      do_op(2'd0, 64'h8000_01FF | (64'(t) << 16));
      do_op(2'd2, '0);
      chk("R9 clip on full index", 64'(idx_clip), 64'(mask_of(t) != 511));
      do_op(2'd1, '0);
      chk("R4 R6 mask wrap", bus_rdata,
          64'h8000_0000 | (64'(t) << 16) | 64'(((mask_of(t)) + 1) & mask_of(t)));
    end

    do_op(2'd0, 64'h0000_0002);
    do_op(2'd3, 64'hDEAD);
    chk("R3 link table write", 64'(wr_tag), 64'h0000_0002);
    chk("R9 clip in range", 64'(idx_clip), 64'd0);
    do_op(2'd0, 64'h0000_0009);
    do_op(2'd2, '0);
    chk("R9 clip out of range", 64'(idx_clip), 64'd1);
    chk("R4 link clipped read", bus_rdata, 64'hC000_0001);
    do_op(2'd1, '0);
    chk("R10 pointer held", bus_rdata, 64'h0000_0009);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule